// File: doc/BRIEF.md
# Four-Lane to Single-Bus Pixel Word Multiplexer

The block collects a group of pixel words that arrive side by side on four lanes and sends them out one after another on a single 10-bit parallel bus. Lane 0 goes out first and lane 3 last. The output therefore runs at four times the rate of the input groups. Frame and line structure leave the block as two level strobes, frame valid and line valid, and not as sync words inside the data stream.

Each input group is presented for one cycle with `in_valid`. It carries three markers: `in_sof` for the first group of a frame, `in_eol` for the last group of a line, and `in_eof` for the last group of a frame. The block has a buffer for one group. A group that arrives while the buffer is still draining is dropped, and the block raises a sticky overflow flag. Groups that arrive while no frame is open and that carry no start marker are discarded without any effect.

Top module: `pix_lane_serializer`

## Requirements
- R1: While reset is asserted and after it is released, `out_data` is 0 and `out_fv`, `out_lv` and `out_ovf` are low.
- R2: An accepted group puts lane 0 (`in_data[9:0]`), lane 1 (`[19:10]`), lane 2 (`[29:20]`) and lane 3 (`[39:30]`) on `out_data` in that order, one word per cycle. The first word appears in the cycle after the edge that accepts the group.
- R3: `out_lv` is high in exactly the cycles in which a word of an accepted group is on the bus.
- R4: `out_data` is 0 in every cycle in which `out_lv` is low.
- R5: `out_fv` rises together with the first word of a group that carries `in_sof`, and it stays high between the lines of a frame.
- R6: `out_fv` falls in the same cycle as `out_lv`, directly after the last word of a group marked `in_eof`.
- R7: Inside a line, a group that arrives in the cycle showing the last word of the previous group is accepted, and its words follow with no gap.
- R8: After the last word of a group marked `in_eol`, `out_lv` is low for at least one cycle. A group that arrives in that last-word cycle is dropped as an overflow.
- R9: A group that arrives while the buffer is draining, other than in the slot allowed by R7, sets `out_ovf`. That group is never emitted, the group already in the buffer finishes unchanged, and `out_ovf` stays high until reset.
- R10: With no frame open, a group that does not carry `in_sof` is ignored: no words, no strobes, no overflow.
- R11: A group marked `in_eof` also ends its line, even when `in_eol` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input group present this cycle |
| in_data | input | 40 | Four 10-bit lane words, lane 0 in the low bits |
| in_sof | input | 1 | Group opens a frame |
| in_eol | input | 1 | Group closes a line |
| in_eof | input | 1 | Group closes the frame |
| out_data | output | 10 | Multiplexed pixel word, zero when idle |
| out_fv | output | 1 | Frame valid strobe |
| out_lv | output | 1 | Line valid strobe |
| out_ovf | output | 1 | Sticky overflow flag |

## Verification
A phase counter that is off by one shows up at once as a lane word out of order, or as a line-valid pulse whose length is not a multiple of four cycles. A busy or end-of-line bit that is stale shows up within one group time: the line strobe is missing between lines, or the overflow flag rises too early or not at all. A frame bit that is wrong shows up one cycle after the last word of a frame, when frame valid and line valid fail to fall together, or at the next group sent with no frame open, when that group produces output.

// File: rtl/pix_lane_serializer.sv
module pix_lane_serializer #(
  parameter int DW    = 10,
  parameter int LANES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [LANES*DW-1:0] in_data,
  input  logic                in_sof,
  input  logic                in_eol,
  input  logic                in_eof,
  output logic [DW-1:0]       out_data,
  output logic                out_fv,
  output logic                out_lv,
  output logic                out_ovf
);
  localparam int PW = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [PW-1:0] LAST = PW'(LANES - 1);

  logic [LANES*DW-1:0] hold_q;
  logic [PW-1:0]       phase_q;
  logic                busy_q, eol_q, eof_q, fv_q, ovf_q;

  wire line_end  = in_eol | in_eof;
  wire in_frame  = fv_q | in_sof;
  wire at_last   = busy_q && (phase_q == LAST);
  wire slot_free = !busy_q || (at_last && !eol_q);
  wire take      = in_valid && in_frame && slot_free;
  wire clash     = in_valid && in_frame && !slot_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      phase_q <= '0;
      busy_q  <= 1'b0;
      eol_q   <= 1'b0;
      eof_q   <= 1'b0;
      fv_q    <= 1'b0;
    end else if (take) begin
      hold_q  <= in_data;
      phase_q <= '0;
      busy_q  <= 1'b1;
      eol_q   <= line_end;
      eof_q   <= in_eof;
      if (in_sof) fv_q <= 1'b1;
    end else if (at_last) begin
      busy_q <= 1'b0;
      if (eof_q) fv_q <= 1'b0;
    end else if (busy_q) begin
      phase_q <= phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ovf_q <= 1'b0;
    else if (clash) ovf_q <= 1'b1;
  end

  assign out_data = busy_q ? hold_q[int'(phase_q)*DW +: DW] : '0;
  assign out_lv   = busy_q;
  assign out_fv   = fv_q;
  assign out_ovf  = ovf_q;
endmodule

// File: rtl/pix_lane_serializer_chk.sv
module pix_lane_serializer_chk #(
  parameter int DW    = 10,
  parameter int LANES = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_sof,
  input logic [DW-1:0] out_data,
  input logic          out_fv,
  input logic          out_lv,
  input logic          out_ovf
);
  logic [15:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (out_lv) run_q <= run_q + 16'd1;
    else             run_q <= '0;
  end

  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !out_lv |-> (out_data == '0)); // R4
  AST_LV_INSIDE_FV: assert property (@(posedge clk) disable iff (!rst_n)
    out_lv |-> out_fv); // R5
  AST_LINE_WHOLE_GROUPS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_lv) |-> ((run_q % LANES) == 0)); // R3
  AST_FV_LV_FALL_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_fv) |-> $fell(out_lv)); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    out_ovf |=> out_ovf); // R9
  AST_IGNORE_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_fv && !out_lv && in_valid && !in_sof) |=> (!out_lv && !out_fv)); // R10
endmodule

bind pix_lane_serializer pix_lane_serializer_chk #(.DW(DW), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
  .out_data(out_data), .out_fv(out_fv), .out_lv(out_lv), .out_ovf(out_ovf)
);

// File: tb/test_pix_lane_serializer.sv
`timescale 1ns/1ps
module test_pix_lane_serializer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [39:0] in_data = '0;
  logic        in_sof = 1'b0, in_eol = 1'b0, in_eof = 1'b0;
  logic [9:0]  out_data;
  logic        out_fv, out_lv, out_ovf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit frame_open = 1'b0;

  always #10 clk = ~clk;

  pix_lane_serializer i_pix_lane_serializer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eol(in_eol), .in_eof(in_eof),
    .out_data(out_data), .out_fv(out_fv), .out_lv(out_lv), .out_ovf(out_ovf)
  );

  // {gap[3:0], sof, eol, eof, base[9:0]}
  localparam logic [16:0] VEC [7] = '{
    {4'd1, 1'b1, 1'b0, 1'b0, 10'h010},
    {4'd0, 1'b0, 1'b1, 1'b0, 10'h020},
    {4'd1, 1'b0, 1'b0, 1'b0, 10'h030},
    {4'd0, 1'b0, 1'b1, 1'b0, 10'h040},
    {4'd1, 1'b0, 1'b1, 1'b1, 10'h050},
    {4'd3, 1'b1, 1'b1, 1'b0, 10'h3F8},
    {4'd1, 1'b0, 1'b1, 1'b1, 10'h100}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] pack(logic [9:0] base);
    logic [39:0] v;
    for (int k = 0; k < 4; k++) v[k*10 +: 10] = base + 10'(k);
    return v;
  endfunction

  task automatic drive(logic [9:0] base, logic sof, logic eol, logic eof);
    in_valid = 1'b1; in_data = pack(base);
    in_sof = sof; in_eol = eol; in_eof = eof;
  endtask

  task automatic idle_inputs();
    in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0; in_eof = 1'b0;
  endtask

  task automatic send(int gap, logic sof, logic eol, logic eof, logic [9:0] base);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      check("R8 line gap lv", 32'(out_lv), 0);
      check("R4 idle bus", 32'(out_data), 0);
      check("R5/R6 fv between groups", 32'(out_fv), 32'(frame_open));
    end
    if (sof) frame_open = 1'b1;
    drive(base, sof, eol, eof);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (k == 0) idle_inputs();
      check(gap == 0 ? "R7 back-to-back word" : "R2 lane order", 32'(out_data), 32'(base + 10'(k)));
      check("R3 lv during words", 32'(out_lv), 1);
      check("R5 fv during words", 32'(out_fv), 1);
    end
    if (eof) frame_open = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 reset lv", 32'(out_lv), 0);
    check("R1 reset fv", 32'(out_fv), 0);
    check("R1 reset ovf", 32'(out_ovf), 0);
    check("R1 reset data", 32'(out_data), 0);
    @(negedge clk);
    rst_n = 1'b1;
    frame_open = 1'b0;
  endtask

  initial begin
    idle_inputs();
    repeat (2) @(negedge clk);
    check("R1 reset lv", 32'(out_lv), 0);
    check("R1 reset fv", 32'(out_fv), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release ovf", 32'(out_ovf), 0);
    check("R1 after release data", 32'(out_data), 0);

    for (int i = 0; i < 7; i++)
      send(int'(VEC[i][16:13]), VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9:0]);
    check("R9 no overflow in legal traffic", 32'(out_ovf), 0);

    // R10: group without start while no frame is open
    @(negedge clk);
    drive(10'h2AA, 1'b0, 1'b0, 1'b0);
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      idle_inputs();
      check("R10 ignored lv", 32'(out_lv), 0);
      check("R10 ignored fv", 32'(out_fv), 0);
      check("R10 ignored data", 32'(out_data), 0);
    end
    check("R10 ignored ovf", 32'(out_ovf), 0);

    // R9: second group while the first drains
    drive(10'h080, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    check("R9 first word", 32'(out_data), 32'h080);
    drive(10'h0C0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    idle_inputs();
    check("R9 ovf raised", 32'(out_ovf), 1);
    check("R9 word1 intact", 32'(out_data), 32'h081);
    @(negedge clk);
    check("R9 word2 intact", 32'(out_data), 32'h082);
    @(negedge clk);
    check("R9 word3 intact", 32'(out_data), 32'h083);
    @(negedge clk);
    check("R9 dropped group not sent", 32'(out_lv), 0);
    check("R9 ovf sticky", 32'(out_ovf), 1);
    check("R5 fv held in frame", 32'(out_fv), 1);
    repeat (3) @(negedge clk);
    check("R9 ovf still set", 32'(out_ovf), 1);
    check("R9 still no output", 32'(out_lv), 0);

    // R8: group arriving in last slot of a line end
    do_reset();
    drive(10'h200, 1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (k == 0) idle_inputs();
      check("R2 word", 32'(out_data), 32'(10'h200 + 10'(k)));
    end
    drive(10'h240, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    idle_inputs();
    check("R8 lv low after line", 32'(out_lv), 0);
    check("R8 slot clash ovf", 32'(out_ovf), 1);
    check("R4 idle bus", 32'(out_data), 0);
    @(negedge clk);
    check("R8 group not sent", 32'(out_lv), 0);

    // R11: frame end without line end still closes the line
    do_reset();
    drive(10'h300, 1'b1, 1'b0, 1'b1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (k == 0) idle_inputs();
      check("R2 word", 32'(out_data), 32'(10'h300 + 10'(k)));
    end
    drive(10'h340, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    idle_inputs();
    check("R11 lv low", 32'(out_lv), 0);
    check("R11 fv low", 32'(out_fv), 0);
    check("R11 clash ovf", 32'(out_ovf), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule